// File: doc/BRIEF.md
# Accumulator-Machine Fetch and Decode Controller

This block is the control and datapath slice of a small 16-bit accumulator computer that brings in one instruction, decodes it and resolves an indirect address. A two-bit sequence counter runs through four timing slots. In each slot the control picks one source for a shared 16-bit bus and raises the load or increment strobes of the program counter, the address register and the instruction register. Memory is outside the block. The address register alone drives the memory address, and memory returns a 16-bit word combinationally.

After the fourth slot the block reports the instruction class with a one-cycle pulse. It then clears its sequence counter so that the next fetch starts at once. Executing the instruction belongs to other logic. That logic can watch the class pulse, the one-hot opcode outputs, the indirect flag and the final address register value.

Top module: `fetch_decode_unit`

## Requirements
- R1: The output `timing` is one-hot, and bit k marks slot Tk. Reset gives T0. The slots advance T0, T1, T2, T3 on successive clocks, and T0 follows T3.
- R2: While reset is held, the program counter loads the parameter START_ADDR and `classValid` is 0.
- R3: In T0, `busSel` is 3'b010 and `busValue` carries the program counter zero-extended. At that edge the address register takes the program counter. `memAddr` always shows the address register.
- R4: In T1, `busSel` is 3'b111, `busValue` equals `memRdata`, and `irLoad` and `pcInc` are both 1. On the same edge the instruction register takes the bus and the program counter increments modulo 4096 (4095 goes to 0).
- R5: In T2, `busSel` is 3'b101 and the bus carries the instruction register. At that edge the address register takes instruction bits 11:0 and `indirFlag` takes instruction bit 15.
- R6: `opDecode` is one-hot. Bit k is 1 exactly when instruction bits 14:12 equal k, so bit 7 flags opcode 111 and bits 0..6 flag memory-reference opcodes.
- R7: In T3, when `opDecode[7]` is 0 and `indirFlag` is 1, `busSel` is 3'b111 and the address register takes `memRdata[11:0]`. In every other case `busSel` is 3'b000, `busValue` is 0 and the address register holds its value.
- R8: `classValid` is 1 during T3 and only then. During that slot `classCode` is {opDecode[7], indirFlag}, where 00 means direct memory reference, 01 indirect memory reference, 10 register reference and 11 input/output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memRdata | input | 16 | Word read from memory at `memAddr` (combinational) |
| memAddr | output | 12 | Memory address, the address register |
| busSel | output | 3 | Bus source code: 000 none, 010 PC, 101 IR, 111 memory |
| busValue | output | 16 | Value on the shared bus |
| pcOut | output | 12 | Program counter |
| irOut | output | 16 | Instruction register |
| indirFlag | output | 1 | Indirect flip-flop |
| opDecode | output | 8 | One-hot opcode decode |
| timing | output | 4 | One-hot timing slots T0..T3 |
| arLoad | output | 1 | Address register load strobe |
| irLoad | output | 1 | Instruction register load strobe |
| pcInc | output | 1 | Program counter increment strobe |
| classValid | output | 1 | One-cycle class pulse in T3 |
| classCode | output | 2 | Instruction class |

## Verification
Two things happen on the same T1 edge: the instruction register loads from memory and the program counter increments. The bench starts the program counter at 0xFF8, so within a few instructions this shared edge also carries the counter's wrap from 4095 to 0. In T2 it checks both the instruction register and the wrapped counter against its own running model. A second coincidence falls in T3, where the class pulse and the indirect address load share a slot. Random words with bit 15 forced on part of the time provoke it. The bench judges the class code in T3 and the address in the following T0 against the pointer word it wrote to memory.

// File: rtl/fdu_pkg.sv
package fdu_pkg;
  localparam logic [2:0] SEL_NONE = 3'b000;
  localparam logic [2:0] SEL_PC   = 3'b010;
  localparam logic [2:0] SEL_IR   = 3'b101;
  localparam logic [2:0] SEL_MEM  = 3'b111;

  typedef struct packed {
    logic [2:0] busSel;
    logic       arLoad;
    logic       irLoad;
    logic       pcInc;
    logic       iLoad;
  } fduStrobes_t;
endpackage

// File: rtl/fdu_control.sv
module fdu_control
  import fdu_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [OP_W-1:0]        irOp,
  input  logic                   iFlag,
  output fduStrobes_t            strobes,
  output logic [3:0]             timing,
  output logic [(1<<OP_W)-1:0]   opDecode,
  output logic                   classValid,
  output logic [1:0]             classCode
);
  localparam int SLOT_N = 4;
  localparam int SC_W   = $clog2(SLOT_N);
  localparam int DEC_N  = 1 << OP_W;
  localparam logic [SC_W-1:0] LAST_SLOT = SC_W'(SLOT_N - 1);

  logic [SC_W-1:0] sc;
  logic            topOp;

  always_ff @(posedge clk) begin
    if (!rstN)                sc <= '0;
    else if (sc == LAST_SLOT) sc <= '0;
    else                      sc <= sc + SC_W'(1);
  end

  for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
    assign timing[k] = (sc == SC_W'(k));
  end

  for (genvar k = 0; k < DEC_N; k++) begin : g_dec
    assign opDecode[k] = (irOp == OP_W'(k));
  end

  assign topOp = opDecode[DEC_N-1];

  always_comb begin
    strobes = '0;
    strobes.busSel = SEL_NONE;
    unique case (sc)
      2'd0: begin
        strobes.busSel = SEL_PC;
        strobes.arLoad = 1'b1;
      end
      2'd1: begin
        strobes.busSel = SEL_MEM;
        strobes.irLoad = 1'b1;
        strobes.pcInc  = 1'b1;
      end
      2'd2: begin
        strobes.busSel = SEL_IR;
        strobes.arLoad = 1'b1;
        strobes.iLoad  = 1'b1;
      end
      default: begin
        if (!topOp && iFlag) begin
          strobes.busSel = SEL_MEM;
          strobes.arLoad = 1'b1;
        end
      end
    endcase
  end

  assign classValid = (sc == LAST_SLOT);
  assign classCode  = {topOp, iFlag};

  assert_slot_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sc == LAST_SLOT) |=> (sc == '0));
  assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sc != LAST_SLOT) |=> (sc == $past(sc) + SC_W'(1)));
  assert_decode_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(opDecode));
  assert_class_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    classValid |=> !classValid);
endmodule

// File: rtl/fdu_datapath.sv
module fdu_datapath
  import fdu_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              WORD_W     = 16,
  parameter int              OP_W       = 3,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  fduStrobes_t         ctl,
  input  logic [WORD_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   busValue,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [WORD_W-1:0]   irOut,
  output logic [OP_W-1:0]     irOp,
  output logic                iFlag
);
  localparam int OP_LSB = WORD_W - 1 - OP_W;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ar;
  logic [WORD_W-1:0] ir;
  logic              iReg;

  always_comb begin
    unique case (ctl.busSel)
      SEL_PC:  busValue = WORD_W'(pc);
      SEL_IR:  busValue = ir;
      SEL_MEM: busValue = memRdata;
      default: busValue = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc   <= START_ADDR;
      ar   <= '0;
      ir   <= '0;
      iReg <= 1'b0;
    end else begin
      if (ctl.pcInc)  pc   <= pc + ADDR_W'(1);
      if (ctl.arLoad) ar   <= busValue[ADDR_W-1:0];
      if (ctl.irLoad) ir   <= busValue;
      if (ctl.iLoad)  iReg <= busValue[WORD_W-1];
    end
  end

  assign memAddr = ar;
  assign pcOut   = pc;
  assign irOut   = ir;
  assign irOp    = ir[OP_LSB +: OP_W];
  assign iFlag   = iReg;

  assert_ar_takes_pc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.arLoad && ctl.busSel == SEL_PC) |=> (ar == $past(pc)));
  assert_fetch_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.irLoad |=> (ir == $past(memRdata) && pc == $past(pc) + ADDR_W'(1)));
  assert_addr_from_ir_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.iLoad |=> (ar == $past(ir[ADDR_W-1:0]) && iReg == $past(ir[WORD_W-1])));
  assert_indirect_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.arLoad && ctl.busSel == SEL_MEM) |=> (ar == $past(memRdata[ADDR_W-1:0])));
endmodule

// File: rtl/fetch_decode_unit.sv
module fetch_decode_unit
  import fdu_pkg::*;
#(
  parameter logic [11:0] START_ADDR = 12'h000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] memRdata,
  output logic [11:0] memAddr,
  output logic [2:0]  busSel,
  output logic [15:0] busValue,
  output logic [11:0] pcOut,
  output logic [15:0] irOut,
  output logic        indirFlag,
  output logic [7:0]  opDecode,
  output logic [3:0]  timing,
  output logic        arLoad,
  output logic        irLoad,
  output logic        pcInc,
  output logic        classValid,
  output logic [1:0]  classCode
);
  localparam int ADDR_W = 12;
  localparam int WORD_W = 16;
  localparam int OP_W   = 3;

  fduStrobes_t       strobes;
  logic [OP_W-1:0]   irOp;

  fdu_control #(.OP_W(OP_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .irOp       (irOp),
    .iFlag      (indirFlag),
    .strobes    (strobes),
    .timing     (timing),
    .opDecode   (opDecode),
    .classValid (classValid),
    .classCode  (classCode)
  );

  fdu_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .OP_W       (OP_W),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .busValue (busValue),
    .pcOut    (pcOut),
    .irOut    (irOut),
    .irOp     (irOp),
    .iFlag    (indirFlag)
  );

  assign busSel = strobes.busSel;
  assign arLoad = strobes.arLoad;
  assign irLoad = strobes.irLoad;
  assign pcInc  = strobes.pcInc;
endmodule

// File: tb/fetch_decode_unit_tb.sv
module fetch_decode_unit_tb;
  localparam logic [11:0] START = 12'hFF8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memRdata;
  logic [11:0] memAddr;
  logic [2:0]  busSel;
  logic [15:0] busValue;
  logic [11:0] pcOut;
  logic [15:0] irOut;
  logic        indirFlag;
  logic [7:0]  opDecode;
  logic [3:0]  timing;
  logic        arLoad, irLoad, pcInc, classValid;
  logic [1:0]  classCode;

  logic [15:0] benchMem [256];
  int unsigned checks = 0;
  int unsigned fails  = 0;
  logic [11:0] pcExp;

  always #5 clk = ~clk;

  assign memRdata = benchMem[memAddr[7:0]];

  fetch_decode_unit #(.START_ADDR(START)) u_dut (
    .clk(clk), .rstN(rstN), .memRdata(memRdata), .memAddr(memAddr),
    .busSel(busSel), .busValue(busValue), .pcOut(pcOut), .irOut(irOut),
    .indirFlag(indirFlag), .opDecode(opDecode), .timing(timing),
    .arLoad(arLoad), .irLoad(irLoad), .pcInc(pcInc),
    .classValid(classValid), .classCode(classCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] classOf(input logic [15:0] w);
    return {w[14:12] == 3'b111, w[15]};
  endfunction

  function automatic bit isIndirect(input logic [15:0] w);
    return (w[14:12] != 3'b111) && w[15];
  endfunction

  // Entered at the negedge inside T0; leaves at the negedge of the next T0.
  task automatic doInstr(input logic [15:0] w, input logic [15:0] ptr);
    logic [11:0] arNext;
    benchMem[pcExp[7:0]] = w;
    check(timing == 4'b0001, "R1", "timing T0", 32'(timing), 32'h1);
    check(busSel == 3'b010, "R3", "busSel T0", 32'(busSel), 32'h2);
    check(busValue == {4'h0, pcExp}, "R3", "bus PC", 32'(busValue), 32'(pcExp));
    check(arLoad == 1'b1, "R3", "arLoad T0", 32'(arLoad), 32'h1);
    check(classValid == 1'b0, "R8", "classValid T0", 32'(classValid), 32'h0);
    @(negedge clk); // T1
    check(memAddr == pcExp, "R3", "AR from PC", 32'(memAddr), 32'(pcExp));
    check(timing == 4'b0010, "R1", "timing T1", 32'(timing), 32'h2);
    check(busSel == 3'b111 && busValue == w, "R4", "bus mem T1", 32'(busValue), 32'(w));
    check(irLoad && pcInc, "R4", "strobes T1", 32'({irLoad, pcInc}), 32'h3);
    @(negedge clk); // T2
    pcExp = pcExp + 12'd1;
    check(irOut == w, "R4", "IR", 32'(irOut), 32'(w));
    check(pcOut == pcExp, "R4", "PC incremented", 32'(pcOut), 32'(pcExp));
    check(busSel == 3'b101 && busValue == w, "R5", "bus IR T2", 32'(busSel), 32'h5);
    check(opDecode == (8'b1 << w[14:12]), "R6", "decode", 32'(opDecode), 32'(8'b1 << w[14:12]));
    benchMem[w[7:0]] = ptr;
    @(negedge clk); // T3
    check(timing == 4'b1000, "R1", "timing T3", 32'(timing), 32'h8);
    check(memAddr == w[11:0], "R5", "AR from IR", 32'(memAddr), 32'(w[11:0]));
    check(indirFlag == w[15], "R5", "indirect flag", 32'(indirFlag), 32'(w[15]));
    check(classValid == 1'b1, "R8", "classValid T3", 32'(classValid), 32'h1);
    check(classCode == classOf(w), "R8", "classCode", 32'(classCode), 32'(classOf(w)));
    if (isIndirect(w))
      check(busSel == 3'b111, "R7", "bus mem T3", 32'(busSel), 32'h7);
    else
      check(busSel == 3'b000 && busValue == 16'h0, "R7", "bus idle T3", 32'(busSel), 32'h0);
    arNext = isIndirect(w) ? ptr[11:0] : w[11:0];
    @(negedge clk); // next T0
    check(memAddr == arNext, "R7", "AR after T3", 32'(memAddr), 32'(arNext));
    check(timing == 4'b0001, "R1", "T0 after T3", 32'(timing), 32'h1);
  endtask

  initial begin
    logic [15:0] w;
    logic [15:0] p;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) benchMem[i] = 16'h0;
    repeat (3) @(posedge clk);
    check(pcOut == START, "R2", "PC at reset", 32'(pcOut), 32'(START));
    check(classValid == 1'b0, "R2", "classValid at reset", 32'(classValid), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    pcExp = START;
    check(timing == 4'b0001, "R1", "timing after reset", 32'(timing), 32'h1);
    check(pcOut == START, "R2", "PC after reset", 32'(pcOut), 32'(START));
    // Directed: one of each class, and pointer cell aliasing the fetch cell.
    doInstr(16'h0ABC, 16'h1234);   // direct, class 00
    doInstr(16'h8055, 16'hF9A7);   // indirect, class 01
    doInstr(16'h7001, 16'hFFFF);   // register, class 10
    doInstr(16'hF123, 16'h0000);   // input/output, class 11
    doInstr(16'hE0FC, 16'h5FFF);   // indirect, pointer at the fetch cell
    doInstr(16'h8FFF, 16'hAFFF);   // indirect through address 4095
    for (int n = 0; n < 300; n++) begin
      w = 16'($urandom);
      p = 16'($urandom);
      if (n % 3 == 0) w[15] = 1'b1;
      doInstr(w, p);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule